// File: doc/BRIEF.md
# Three-Level Flying-Capacitor Leg Modulator

This block drives the four switches of one three-level flying-capacitor phase leg. Every carrier period it takes an offset level (0 or 1) and a duty fraction from a sample-rate controller. A triangular carrier is compared against the duty to decide how long the leg sits at the upper of its two adjacent output levels. The inner cell holds the centre switch pair and the outer cell holds the outermost pair. Each cell is driven as a complementary high/low gate pair, with a dead-time gap on every change.

The middle output level can be reached through two redundant switch states. The block picks between them once per carrier period. It compares the measured flying-capacitor voltage with a half-bus reference and looks at the sign of the leg current, so that the state it picks pushes the capacitor voltage back toward nominal. The offset, the duty and this selection are all captured at the start of a period and held until the next one. This keeps the switching pattern free of chatter when the measurements are noisy.

The carrier half-period is a parameter. With the default of 12500 and a 125 MHz clock, the carrier runs at 5 kHz.

Top module: `fc_leg_pwm`

## Requirements
- R1: While `rst_n` is low, both low-side gates (`outer_lo`, `inner_lo`) are on and both high-side gates are off. After release with zero duty and zero offset, the leg stays at level 0.
- R2: The carrier is a triangle that counts 0 up to HALF-1 and back down to 0, dwelling two cycles at each end. A period is therefore 2*HALF clock cycles.
- R3: With offset 0, the leg sits at the middle level for 2*duty cycles of each period and at level 0 for the rest. Duty 0 gives level 0 throughout, and duty HALF gives the middle level throughout.
- R4: With offset 1, the leg sits at level 2 for 2*duty cycles of each period and at the middle level for the rest.
- R5: The cell commands are encoded by level as follows:
  - Level 0 sets both cells to their low side.
  - Level 2 sets both cells to their high side.
  - Middle state A sets the outer cell high and the inner cell low.
  - Middle state B sets the inner cell high and the outer cell low.
- R6: Middle state A is chosen when (`vcap` < `half_ref`) equals `i_out_pos`, where `i_out_pos`=1 means current flows out of the leg. Otherwise state B is chosen. `vcap` equal to `half_ref` counts as not low.
- R7: Offset, duty and middle-state choice are captured once per period, at the period start. Input changes during a period do not alter the switch pattern until the next period.
- R8: The two gates of a cell are never on together. When a cell's command changes, both of its gates are off for `dead`+1 cycles before the new side turns on.
- R9: If a cell's command returns to its previous value before `dead`+1 cycles have elapsed, the new side never turns on. The previous side resumes at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| offset | input | 1 | Lower of the two output levels to switch between (0 or 1) |
| duty | input | $clog2(HALF+1) | Time fraction at the upper level, 0..HALF |
| vcap | input | VW | Measured flying-capacitor voltage |
| half_ref | input | VW | Nominal capacitor voltage (half the DC bus) |
| i_out_pos | input | 1 | 1 when leg current flows out of the leg |
| dead | input | DW | Dead-time count; the gap is dead+1 cycles |
| outer_hi | output | 1 | Outer cell high-side gate |
| outer_lo | output | 1 | Outer cell low-side gate |
| inner_hi | output | 1 | Inner cell high-side gate |
| inner_lo | output | 1 | Inner cell low-side gate |

## Verification
The gate-pair properties assume nothing about the measurement inputs. They do rely on the command to a cell coming only from the carrier compare. The per-period gate counts the bench predicts assume that `duty` stays within 0..HALF and that `dead` is held constant while a pattern runs. The stimulus changes inputs only between patterns and allows three full periods to settle before counting over exactly one period. The stimulus also keeps each command pulse either wider than the dead gap or deliberately narrower, which gives closed-form expected counts.

// File: rtl/fc_leg_pwm.sv
module fc_leg_pwm #(
  parameter int HALF = 12500,
  parameter int VW = 12,
  parameter int DW = 4,
  localparam int CW = $clog2(HALF + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          offset,
  input  logic [CW-1:0] duty,
  input  logic [VW-1:0] vcap,
  input  logic [VW-1:0] half_ref,
  input  logic          i_out_pos,
  input  logic [DW-1:0] dead,
  output logic          outer_hi,
  output logic          outer_lo,
  output logic          inner_hi,
  output logic          inner_lo
);

  logic [CW-1:0] cnt;
  logic          up;
  logic          off_q, sel_a_q;
  logic [CW-1:0] duty_q;
  logic [1:0]    cmd;
  logic [1:0]    g_hi, g_lo;

  wire at_top     = (cnt == CW'(HALF - 1));
  wire at_bot     = (cnt == '0);
  wire period_end = !up && at_bot;
  wire sel_a      = ((vcap < half_ref) == i_out_pos);
  wire upper      = (cnt < duty_q);

  wire outer_t = off_q ? (upper | sel_a_q)  : (upper & sel_a_q);
  wire inner_t = off_q ? (upper | !sel_a_q) : (upper & !sel_a_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      up  <= 1'b1;
    end else if (up) begin
      if (at_top) up <= 1'b0;
      else        cnt <= cnt + 1'b1;
    end else begin
      if (at_bot) up <= 1'b1;
      else        cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q   <= 1'b0;
      duty_q  <= '0;
      sel_a_q <= 1'b0;
    end else if (period_end) begin
      off_q   <= offset;
      duty_q  <= duty;
      sel_a_q <= sel_a;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd <= '0;
    else        cmd <= {outer_t, inner_t};
  end

  for (genvar c = 0; c < 2; c++) begin : g_cell
    logic          cur;
    logic [DW-1:0] dcnt;
    wire           settled = (cmd[c] == cur);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cur  <= 1'b0;
        dcnt <= '0;
      end else if (settled) begin
        dcnt <= '0;
      end else if (dcnt == dead) begin
        cur  <= cmd[c];
        dcnt <= '0;
      end else begin
        dcnt <= dcnt + 1'b1;
      end
    end

    assign g_hi[c] = settled & cur;
    assign g_lo[c] = settled & ~cur;
  end

  assign outer_hi = g_hi[1];
  assign outer_lo = g_lo[1];
  assign inner_hi = g_hi[0];
  assign inner_lo = g_lo[0];

endmodule

// File: rtl/fc_leg_pwm_chk.sv
module fc_leg_pwm_chk (
  input logic clk,
  input logic rst_n,
  input logic outer_hi,
  input logic outer_lo,
  input logic inner_hi,
  input logic inner_lo
);

  // R8
  outer_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(outer_hi && outer_lo));

  // R8
  inner_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(inner_hi && inner_lo));

  // R8
  outer_gap_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(outer_hi) |-> !outer_lo);

  // R8
  outer_gap_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(outer_lo) |-> !outer_hi);

  // R8
  inner_gap_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(inner_hi) |-> !inner_lo);

  // R8
  inner_gap_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(inner_lo) |-> !inner_hi);

endmodule

bind fc_leg_pwm fc_leg_pwm_chk u_fc_leg_pwm_chk (
  .clk(clk), .rst_n(rst_n),
  .outer_hi(outer_hi), .outer_lo(outer_lo),
  .inner_hi(inner_hi), .inner_lo(inner_lo)
);

// File: tb/test_fc_leg_pwm.sv
module test_fc_leg_pwm;
  localparam int HALF = 10;
  localparam int VW = 12;
  localparam int DW = 4;
  localparam int CW = $clog2(HALF + 1);
  localparam int P = 2 * HALF;
  localparam int NV = 14;

  // off, duty, vcap, i_out_pos, dead, outer cmd length, inner cmd length
  localparam int TBL [NV][7] = '{
    '{0,  5,  900, 1, 2, 10,  0},
    '{0,  5,  900, 0, 2,  0, 10},
    '{0,  7, 1100, 1, 2,  0, 14},
    '{0,  7, 1100, 0, 2, 14,  0},
    '{1,  3,  900, 1, 2, 20,  6},
    '{1,  3,  900, 0, 2,  6, 20},
    '{1,  8, 1000, 1, 2, 16, 20},
    '{0,  0,  900, 1, 2,  0,  0},
    '{1, 10,  900, 0, 2, 20, 20},
    '{0, 10,  900, 1, 2, 20,  0},
    '{0,  4,  900, 1, 0,  8,  0},
    '{1,  4, 1100, 1, 5,  8, 20},
    '{0,  1,  900, 1, 3,  2,  0},
    '{1,  6, 1000, 0, 1, 20, 12}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic offset = 1'b0;
  logic [CW-1:0] duty = '0;
  logic [VW-1:0] vcap = '0;
  logic [VW-1:0] half_ref = VW'(1000);
  logic i_out_pos = 1'b0;
  logic [DW-1:0] dead = '0;
  logic outer_hi, outer_lo, inner_hi, inner_lo;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  fc_leg_pwm #(.HALF(HALF), .VW(VW), .DW(DW)) i_fc_leg_pwm (
    .clk(clk), .rst_n(rst_n), .offset(offset), .duty(duty),
    .vcap(vcap), .half_ref(half_ref), .i_out_pos(i_out_pos), .dead(dead),
    .outer_hi(outer_hi), .outer_lo(outer_lo),
    .inner_hi(inner_hi), .inner_lo(inner_lo)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic void exp_gates(input int len, input int dt,
                                    output int hi, output int lo);
    if (len == 0) begin hi = 0; lo = P; end
    else if (len == P) begin hi = P; lo = 0; end
    else if (len < dt + 1) begin hi = 0; lo = P - len; end
    else if (P - len < dt + 1) begin hi = len; lo = 0; end
    else begin hi = len - dt - 1; lo = P - len - dt - 1; end
  endfunction

  task automatic measure(output int oh, output int ol, output int ih, output int il);
    oh = 0; ol = 0; ih = 0; il = 0;
    for (int k = 0; k < P; k++) begin
      @(negedge clk);
      oh += int'(outer_hi); ol += int'(outer_lo);
      ih += int'(inner_hi); il += int'(inner_lo);
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int oh, ol, ih, il, eoh, eol, eih, eil;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset gates", {outer_hi, outer_lo, inner_hi, inner_lo}, 4'b0101);
    rst_n = 1'b1;
    repeat (2 * P) @(negedge clk);
    check("R1 level 0 after reset", {outer_hi, outer_lo, inner_hi, inner_lo}, 4'b0101);

    for (int v = 0; v < NV; v++) begin
      offset = TBL[v][0][0];
      duty = CW'(TBL[v][1]);
      vcap = VW'(TBL[v][2]);
      i_out_pos = TBL[v][3][0];
      dead = DW'(TBL[v][4]);
      repeat (3 * P) @(negedge clk);
      measure(oh, ol, ih, il);
      exp_gates(TBL[v][5], TBL[v][4], eoh, eol);
      exp_gates(TBL[v][6], TBL[v][4], eih, eil);
      check($sformatf("R3 R4 R5 R6 R8 R9 vec %0d outer_hi", v), oh, eoh);
      check($sformatf("R3 R4 R5 R6 R8 R9 vec %0d outer_lo", v), ol, eol);
      check($sformatf("R3 R4 R5 R6 R8 vec %0d inner_hi", v), ih, eih);
      check($sformatf("R3 R4 R5 R6 R8 vec %0d inner_lo", v), il, eil);
    end

    // R2 carrier period: spacing between rising edges of a one-cycle pulse
    begin
      int first, second, t;
      offset = 1'b0; duty = CW'(1); vcap = VW'(900); i_out_pos = 1'b1; dead = '0;
      repeat (3 * P) @(negedge clk);
      first = -1; second = -1; t = 0;
      while (second < 0 && t < 3 * P) begin
        logic prev;
        prev = outer_hi;
        @(negedge clk);
        t++;
        if (!prev && outer_hi) begin
          if (first < 0) first = t; else second = t;
        end
      end
      check("R2 carrier period", second - first, P);
    end

    // R7 selection held per period: current sign toggling every cycle
    begin
      int changes, mid_on;
      logic prev;
      offset = 1'b0; duty = CW'(HALF); vcap = VW'(900); dead = DW'(1);
      for (int k = 0; k < 3 * P; k++) begin
        @(negedge clk);
        i_out_pos = ~i_out_pos;
      end
      changes = 0; mid_on = 0; prev = outer_hi;
      for (int k = 0; k < 2 * P; k++) begin
        @(negedge clk);
        i_out_pos = ~i_out_pos;
        if (outer_hi != prev) changes++;
        prev = outer_hi;
        mid_on += int'(outer_hi | inner_hi);
      end
      check("R7 no state change within toggling window", changes, 0);
      check("R7 middle state held throughout", mid_on, 2 * P);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule